// File: doc/BRIEF.md
# Circular Instruction Prefetch Stack

The block keeps a small ring of 64-bit instruction doublewords ahead of the decoder. It sends its own sequential fetch requests to memory and writes the returned doublewords into the ring. It gives the doubleword at the current decode address to the decoder. Three doubleword address registers track the ring. The decode pointer names the doubleword now being decoded. The upper bound names the newest doubleword requested. The lower bound names the oldest doubleword that is still resident. Doublewords the decoder has already used are not dropped at once. They stay in their slots until a new fetch overwrites them, so the ring always covers a window of recent addresses.

A redirect input, driven by branch or interrupt logic, moves all three pointers to a new target address and empties the ring. Fetching restarts from that target on the following cycle. Responses still in flight from before the redirect are thrown away. Memory must answer requests in the order they were made, after a fixed delay. The decoder advances by one doubleword with a single strobe.

Top module: `ipf_stack`

## Requirements
- R1: After reset no fetch request is made and `dec_valid` stays low until the first redirect.
- R2: In a cycle with `redir_valid` high, `req_valid` is low. In the next cycle the decode address, `win_lo` and `win_hi` all equal the target, `dec_valid` is low, and a request is made for the target address.
- R3: While there is room, one request is made per cycle, and each request address is one above the previous one (modulo 2^ADDR_W).
- R4: Requests stop once eight doublewords at or above the decode address have been requested (upper bound = decode address + 7). They resume as soon as the decode address advances.
- R5: The lower bound holds until a new request would land in its slot (low three address bits equal). Then the lower and upper bounds both step by one. `win_hi - win_lo` never exceeds 7.
- R6: Responses to requests made before a redirect are discarded and never reach the decoder.
- R7: The doubleword at address A is kept in slot A mod 8, and responses fill slots in request order. `dec_valid` rises only once the doubleword at `dec_addr` has returned, and `dec_data` then equals the memory content at `dec_addr`.
- R8: `dec_advance` has no effect while `dec_valid` is low, so `dec_addr` is unchanged.
- R9: If `redir_valid` and `dec_advance` are high in the same cycle, the redirect wins and `dec_addr` becomes the target, not the target plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Restart fetching at `redir_addr` |
| redir_addr | input | ADDR_W | Doubleword target address |
| req_valid | output | 1 | Fetch request this cycle |
| req_addr | output | ADDR_W | Doubleword address requested |
| rsp_valid | input | 1 | In-order fetch response |
| rsp_data | input | DATA_W | Returned doubleword |
| dec_valid | output | 1 | `dec_data` holds the doubleword at `dec_addr` |
| dec_addr | output | ADDR_W | Decode pointer |
| dec_data | output | DATA_W | Doubleword at the decode pointer |
| dec_advance | input | 1 | Decoder consumed the current doubleword |
| win_lo | output | ADDR_W | Lower bound: oldest resident doubleword |
| win_hi | output | ADDR_W | Upper bound: newest requested doubleword |

## Verification
Requests are combinational from registered state. A redirect therefore suppresses the request in its own cycle, and the first request for the target appears one cycle later. With a memory delay of L edges, that doubleword reaches `dec_valid` L+1 cycles after it was requested. The decode pointer and both bounds move one cycle after the advance or fetch that caused them. The bench drives inputs just after the falling edge. Its monitor and its directed checks sample half a cycle later, before the next rising edge. Each expected value is therefore compared in the cycle where the register chain above says it is due.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

    // Fetch engine phase
    typedef enum logic [1:0] {
        ST_IDLE,   // out of reset, nothing requested
        ST_FIRST,  // redirect taken, target not yet requested
        ST_RUN     // streaming sequential requests
    } fetch_st_e;

endpackage

// File: rtl/ipf_ptrs.sv
module ipf_ptrs
    import ipf_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_addr,
    input  logic              adv_ok,
    output logic [ADDR_W-1:0] ir,
    output logic [ADDR_W-1:0] ub,
    output logic [ADDR_W-1:0] lb,
    output logic [ADDR_W-1:0] req_addr,
    output logic              issue,
    output logic              have
);

    localparam int unsigned       IDX_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SLOTS = ADDR_W'(DEPTH);

    typedef struct packed {
        fetch_st_e         st;
        logic [ADDR_W-1:0] ir;
        logic [ADDR_W-1:0] ub;
        logic [ADDR_W-1:0] lb;
    } ptr_t;

    ptr_t              q, d;
    logic [ADDR_W-1:0] ahead;
    logic [ADDR_W-1:0] nxt;
    logic              room;
    logic              wrap;

    always_comb begin
        d     = q;
        // doublewords requested at or beyond the decode pointer (0..DEPTH)
        ahead = q.ub + ONE - q.ir;
        nxt   = (q.st == ST_FIRST) ? q.ub : q.ub + ONE;
        room  = (q.st == ST_FIRST) || ((q.st == ST_RUN) && (ahead < SLOTS));
        issue = room && !redir_valid;
        // new fetch lands on the oldest resident slot
        wrap  = (q.st == ST_RUN) && (nxt[IDX_W-1:0] == q.lb[IDX_W-1:0]);

        if (redir_valid) begin
            d.st = ST_FIRST;
            d.ir = redir_addr;
            d.ub = redir_addr;
            d.lb = redir_addr;
        end else begin
            if (adv_ok) begin
                d.ir = q.ir + ONE;
            end
            if (issue) begin
                d.st = ST_RUN;
                d.ub = nxt;
                if (wrap) begin
                    d.lb = q.lb + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ir: '0, ub: '0, lb: '0};
        end else begin
            q <= d;
        end
    end

    assign ir       = q.ir;
    assign ub       = q.ub;
    assign lb       = q.lb;
    assign req_addr = nxt;
    assign have     = (q.st == ST_RUN) && (ahead != '0);

    // R4: never more than DEPTH doublewords requested ahead of decode
    p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |-> ((q.ub + ONE - q.ir) <= SLOTS));

    // R5: bounds never span more than the ring
    p_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |-> ((q.ub - q.lb) < SLOTS));

    // R5: lower bound only moves in step with the upper bound
    p_lb_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(redir_valid) && (q.lb != $past(q.lb)))
            |-> ((q.lb == $past(q.lb) + ONE) && (q.ub == $past(q.ub) + ONE)));

    // R2: redirect collapses all three pointers onto the target
    p_redir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(redir_valid) |-> ((q.st == ST_FIRST) && (q.ir == $past(redir_addr))
                                && (q.ub == q.ir) && (q.lb == q.ir)));

endmodule

// File: rtl/ipf_track.sv
module ipf_track #(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned LAT_MAX = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     redir_valid,
    input  logic [$clog2(DEPTH)-1:0] redir_slot,
    input  logic                     issue,
    input  logic                     rsp_valid,
    output logic                     live_wr,
    output logic [$clog2(DEPTH)-1:0] wr_slot
);

    localparam int unsigned      IDX_W = $clog2(DEPTH);
    localparam int unsigned      CNT_W = $clog2(LAT_MAX + DEPTH + 1);
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
    localparam logic [IDX_W-1:0] I_ONE = IDX_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] pend;  // live requests awaiting data
        logic [CNT_W-1:0] drop;  // stale requests still to be swallowed
        logic [IDX_W-1:0] ret;   // slot of next live response
    } trk_t;

    trk_t q, d;

    always_comb begin
        d       = q;
        live_wr = rsp_valid && !redir_valid && (q.drop == '0);

        if (redir_valid) begin
            d.drop = q.drop + q.pend - {{(CNT_W-1){1'b0}}, rsp_valid};
            d.pend = '0;
            d.ret  = redir_slot;
        end else begin
            if (rsp_valid) begin
                if (q.drop != '0) begin
                    d.drop = q.drop - C_ONE;
                end else begin
                    d.pend = q.pend - C_ONE;
                end
            end
            if (issue) begin
                d.pend = d.pend + C_ONE;
            end
            if (live_wr) begin
                d.ret = q.ret + I_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{pend: '0, drop: '0, ret: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_slot = q.ret;

    // R6: live outstanding requests never exceed the ring size
    p_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.pend <= CNT_W'(DEPTH));

    // R6: every response belongs to some request, live or stale
    p_rsp_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((q.pend + q.drop) != '0));

endmodule

// File: rtl/ipf_slots.sv
module ipf_slots #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_all,
    input  logic                     clr_en,
    input  logic [$clog2(DEPTH)-1:0] clr_slot,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_slot,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_slot,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_ok
);

    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] word [DEPTH];
    logic [DEPTH-1:0]  full;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [IDX_W-1:0] ME = IDX_W'(g);

        logic [DATA_W-1:0] dw_d, dw_q;
        logic              v_d, v_q;

        always_comb begin
            dw_d = dw_q;
            v_d  = v_q;
            if (clr_all) begin
                v_d = 1'b0;
            end else if (wr_en && (wr_slot == ME)) begin
                dw_d = wr_data;
                v_d  = 1'b1;
            end else if (clr_en && (clr_slot == ME)) begin
                v_d = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dw_q <= '0;
                v_q  <= 1'b0;
            end else begin
                dw_q <= dw_d;
                v_q  <= v_d;
            end
        end

        assign word[g] = dw_q;
        assign full[g] = v_q;
    end

    assign rd_data = word[rd_slot];
    assign rd_ok   = full[rd_slot];

    // R7: a returning doubleword never targets the slot being reclaimed
    p_wr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr_en) |-> (wr_slot != clr_slot));

endmodule

// File: rtl/ipf_stack.sv
module ipf_stack #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned LAT_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_addr,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              dec_valid,
    output logic [ADDR_W-1:0] dec_addr,
    output logic [DATA_W-1:0] dec_data,
    input  logic              dec_advance,
    output logic [ADDR_W-1:0] win_lo,
    output logic [ADDR_W-1:0] win_hi
);

    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] ir, ub, lb, nxt_addr;
    logic              issue, have, adv_ok, live_wr, slot_ok;
    logic [IDX_W-1:0]  wr_slot;

    assign dec_valid = have && slot_ok;
    assign adv_ok    = dec_valid && dec_advance;

    ipf_ptrs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .redir_valid(redir_valid),
        .redir_addr (redir_addr),
        .adv_ok     (adv_ok),
        .ir         (ir),
        .ub         (ub),
        .lb         (lb),
        .req_addr   (nxt_addr),
        .issue      (issue),
        .have       (have)
    );

    ipf_track #(.DEPTH(DEPTH), .LAT_MAX(LAT_MAX)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .redir_valid(redir_valid),
        .redir_slot (redir_addr[IDX_W-1:0]),
        .issue      (issue),
        .rsp_valid  (rsp_valid),
        .live_wr    (live_wr),
        .wr_slot    (wr_slot)
    );

    ipf_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (redir_valid),
        .clr_en  (issue),
        .clr_slot(nxt_addr[IDX_W-1:0]),
        .wr_en   (live_wr),
        .wr_slot (wr_slot),
        .wr_data (rsp_data),
        .rd_slot (ir[IDX_W-1:0]),
        .rd_data (dec_data),
        .rd_ok   (slot_ok)
    );

    assign req_valid = issue;
    assign req_addr  = nxt_addr;
    assign dec_addr  = ir;
    assign win_lo    = lb;
    assign win_hi    = ub;

    // R3: back-to-back requests climb by one doubleword
    p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid) && !$past(redir_valid))
            |-> (req_addr == $past(req_addr) + ADDR_W'(1)));

    // R2: ring is empty right after a redirect
    p_dec_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(redir_valid) |-> !dec_valid);

    // R8: decode pointer frozen while nothing valid is offered
    p_ir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(redir_valid) && !$past(dec_valid)) |-> (dec_addr == $past(dec_addr)));

    // R9: redirect beats a simultaneous advance
    p_redir_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(redir_valid) && $past(dec_advance)) |-> (dec_addr == $past(redir_addr)));

endmodule

// File: tb/test_ipf_stack.sv
`timescale 1ns/1ps
module test_ipf_stack;

    localparam int unsigned AW  = 16;
    localparam int unsigned DW  = 64;
    localparam int unsigned LAT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          redir_valid = 1'b0;
    logic [AW-1:0] redir_addr = '0;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          dec_valid;
    logic [AW-1:0] dec_addr;
    logic [DW-1:0] dec_data;
    logic          dec_advance = 1'b0;
    logic [AW-1:0] win_lo, win_hi;

    always #2.5 clk = ~clk;

    ipf_stack #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(8), .LAT_MAX(16)) i_ipf_stack (
        .clk(clk), .rst_n(rst_n),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dec_valid(dec_valid), .dec_addr(dec_addr), .dec_data(dec_data),
        .dec_advance(dec_advance),
        .win_lo(win_lo), .win_hi(win_hi)
    );

    function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
        return {16'hC0DE, a, ~a, 16'h5A5A};
    endfunction

    // fixed-latency in-order memory
    logic          pv [LAT];
    logic [AW-1:0] pa [LAT];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                pv[i] <= 1'b0;
                pa[i] <= '0;
            end
        end else begin
            pv[0] <= req_valid;
            pa[0] <= req_addr;
            for (int i = 1; i < LAT; i++) begin
                pv[i] <= pv[i-1];
                pa[i] <= pa[i-1];
            end
        end
    end
    assign rsp_valid = pv[LAT-1];
    assign rsp_data  = mem_f(pa[LAT-1]);

    int            nvec = 0;
    int            nerr = 0;
    int            req_cnt = 0;
    int            pop_cnt = 0;
    logic [AW-1:0] exp_req = '0;
    logic [AW-1:0] exp_q [$];
    logic [15:0]   lfsr = 16'hACE1;
    bit            done = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    // driver: one cycle of stimulus; on redirect it loads the scoreboard
    task automatic cycle(input logic r, input logic [AW-1:0] a, input logic adv);
        @(negedge clk);
        redir_valid = r;
        redir_addr  = a;
        dec_advance = adv;
        if (r) begin
            exp_q.delete();
            for (int i = 0; i < 1024; i++) exp_q.push_back(a + AW'(i));
            pop_cnt = 0;
        end
        #2;
    endtask

    // monitor: samples 1 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (redir_valid) begin
                    chk(!req_valid, "R2 no request in redirect cycle", {63'b0, req_valid}, 64'd0);
                    exp_req = redir_addr;
                    req_cnt = 0;
                end else if (req_valid) begin
                    chk(req_addr == exp_req, "R3 request address", {48'b0, req_addr}, {48'b0, exp_req});
                    exp_req = exp_req + AW'(1);
                    req_cnt++;
                end
                if (!redir_valid && dec_valid && dec_advance) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected consumption", {48'b0, dec_addr}, 64'd0);
                    end else begin
                        logic [AW-1:0] e;
                        e = exp_q.pop_front();
                        chk(dec_addr == e, "R7 decode address", {48'b0, dec_addr}, {48'b0, e});
                        chk(dec_data == mem_f(e), "R7 decode data", dec_data, mem_f(e));
                        pop_cnt++;
                    end
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        summary();
    end

    initial begin
        logic [AW-1:0] d;
        // reset
        repeat (3) cycle(1'b0, '0, 1'b0);
        rst_n = 1'b1;
        repeat (3) begin
            cycle(1'b0, '0, 1'b0);
            chk(!req_valid && !dec_valid, "R1 idle after reset", {62'b0, req_valid, dec_valid}, 64'd0);
        end

        // A: fill the window with the decoder stalled
        cycle(1'b1, 16'h0100, 1'b0);
        chk(!req_valid, "R2 redirect cycle request", {63'b0, req_valid}, 64'd0);
        cycle(1'b0, '0, 1'b0);
        chk(dec_addr == 16'h0100 && win_lo == 16'h0100 && win_hi == 16'h0100,
            "R2 pointers at target", {16'b0, dec_addr, win_lo, win_hi}, {16'b0, 48'h010001000100});
        chk(!dec_valid, "R2 empty after redirect", {63'b0, dec_valid}, 64'd0);
        chk(req_valid && req_addr == 16'h0100, "R2 first request", {47'b0, req_valid, req_addr}, {47'b0, 1'b1, 16'h0100});
        repeat (20) cycle(1'b0, '0, 1'b0);
        chk(req_cnt == 8, "R4 window stop", 64'(req_cnt), 64'd8);
        chk(win_lo == 16'h0100, "R5 lower bound holds", {48'b0, win_lo}, 64'h0100);
        chk(win_hi == 16'h0107, "R5 upper bound", {48'b0, win_hi}, 64'h0107);
        chk(dec_valid && dec_data == mem_f(16'h0100), "R7 head data", dec_data, mem_f(16'h0100));

        // B: one advance reopens the window and drags the lower bound
        cycle(1'b0, '0, 1'b1);
        repeat (6) cycle(1'b0, '0, 1'b0);
        chk(req_cnt == 9, "R4 resume after advance", 64'(req_cnt), 64'd9);
        chk(win_lo == 16'h0101 && win_hi == 16'h0108, "R5 bounds step together",
            {32'b0, win_lo, win_hi}, {32'b0, 32'h01010108});
        chk(dec_addr == 16'h0101, "R7 decode pointer", {48'b0, dec_addr}, 64'h0101);

        // C: redirect with simultaneous advance, then advance while empty
        cycle(1'b1, 16'h2000, 1'b1);
        chk(!req_valid, "R2 redirect cycle request mid-stream", {63'b0, req_valid}, 64'd0);
        cycle(1'b0, '0, 1'b1);
        chk(dec_addr == 16'h2000, "R9 redirect beats advance", {48'b0, dec_addr}, 64'h2000);
        chk(!dec_valid, "R2 empty after redirect", {63'b0, dec_valid}, 64'd0);
        repeat (2) begin
            cycle(1'b0, '0, 1'b1);
            chk(!dec_valid && dec_addr == 16'h2000, "R8 advance ignored while empty",
                {47'b0, dec_valid, dec_addr}, 64'h2000);
        end
        repeat (40) cycle(1'b0, '0, 1'b1);
        chk(pop_cnt >= 30, "R7 streaming throughput", 64'(pop_cnt), 64'd30);

        // D: irregular decoder
        repeat (300) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(1'b0, '0, lfsr[0] | lfsr[3]);
            d = win_hi - win_lo;
            chk(d <= 16'd7, "R5 bound span", {48'b0, d}, 64'd7);
        end

        // E: redirect over in-flight responses, twice back to back
        cycle(1'b1, 16'h0F00, 1'b1);
        cycle(1'b0, '0, 1'b1);
        cycle(1'b1, 16'h3000, 1'b1);
        repeat (60) cycle(1'b0, '0, 1'b1);
        chk(pop_cnt >= 40, "R6 clean stream after stale drop", 64'(pop_cnt), 64'd40);

        // F: address wrap
        cycle(1'b1, 16'hFFFA, 1'b1);
        repeat (40) cycle(1'b0, '0, 1'b1);
        chk(pop_cnt >= 25, "R7 stream across address wrap", 64'(pop_cnt), 64'd25);

        // G: decoder stalls, window refills to its limit
        repeat (20) cycle(1'b0, '0, 1'b0);
        d = win_hi - dec_addr;
        chk(d == 16'd7, "R4 full window after stall", {48'b0, d}, 64'd7);
        chk(!req_valid, "R4 no request when full", {63'b0, req_valid}, 64'd0);

        summary();
    end

endmodule